// File: doc/BRIEF.md
# Incremental Delta Charge-Pump DAC Controller

This block converts a stream of sample-to-sample differences into timed charge packets for an external RC integrator. A free-running counter of `CNT_W` bits divides time into sample periods of `2^CNT_W` clocks. At the start of each period the block takes the most recent signed delta and drives a single tri-stateable pin. A positive delta holds the pin high, which adds charge. A negative delta holds it low, which removes charge. The pin is driven for as many clocks as the delta's magnitude and is then released to high impedance, so the integrator holds its voltage.

The producer sends a delta with a one-clock strobe at any time during a period. That delta is applied from the next period boundary onward and cannot disturb the pulse already in progress. At the first clock of every period the block raises a one-clock request, which tells the producer to supply the next difference. Deltas larger than the counter can express are saturated to the largest magnitude. They never wrap, so an overflow can never reverse the direction of charge.

Top module: `idelta_dac`

## Requirements
- R1: A sample period lasts exactly 2^CNT_W clocks. `smp_req` is high for one clock, in the first clock of each period. The first such pulse appears on the 2^CNT_W-th rising edge after reset is released.
- R2: During a period, `drv_en` is high for exactly as many clocks as the applied magnitude. These clocks form one contiguous run that begins in the period's first clock.
- R3: While `drv_en` is high, `drv_level` is 1 for a positive delta and 0 for a negative delta. It stays constant for the whole run.
- R4: While `drv_en` is low (pin released), `drv_level` reads 0.
- R5: A delta given with `smp_strobe` takes effect at the first period boundary after the strobe clock. A strobe inside a period does not change that period's pulse.
- R6: If several strobes fall within one period, only the last one is applied at the next boundary.
- R7: A zero delta gives no enabled clocks. A period whose boundary saw no strobe since the previous boundary also gives no enabled clocks, because each accepted delta is used once.
- R8: Magnitudes above 2^CNT_W-1 are clamped to 2^CNT_W-1 and keep their sign. This includes the most negative input code. They never wrap.
- R9: Synchronous active-high `rst` clears the counter and the stored deltas. While `rst` is high, and in the first clock after it, `drv_en`, `drv_level` and `smp_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_strobe | input | 1 | One-clock strobe that accepts `smp_delta` |
| smp_delta | input | DELTA_W | Signed two's-complement difference from the previous sample |
| drv_en | output | 1 | Pin driver enable; low means high impedance |
| drv_level | output | 1 | Logic level driven while enabled (1 adds charge, 0 removes) |
| smp_req | output | 1 | One-clock pulse in the first clock of each sample period |

## Verification
The pulse is measured over whole periods against positive, negative and zero deltas, and against magnitudes at and beyond the counter limit. This separates errors in the length of the run, in its starting clock and in its direction from errors in the clamp, including the most negative code, which a wrapping clamp would turn into a short pulse. The timing of strobes relative to the boundary is also varied. These cases cover a strobe during an active pulse, two strobes in one period, and a period with no strobe. They tell apart designs that apply a delta too early, keep the first strobe instead of the last, or replay a stale delta.

// File: rtl/idelta_pkg.sv
package idelta_pkg;

    // Drive state of the charge pin: bit 1 = enable, bit 0 = level.
    typedef enum logic [1:0] {
        DRV_RELEASE = 2'b00,
        DRV_SINK    = 2'b10,
        DRV_SOURCE  = 2'b11
    } drive_e;

    // Map "pulse active" and "delta negative" onto a pin drive state.
    function automatic drive_e drive_select(input logic active, input logic negative);
        if (!active)
            return DRV_RELEASE;
        else if (negative)
            return DRV_SINK;
        else
            return DRV_SOURCE;
    endfunction

    function automatic logic drive_enable(input drive_e d);
        return d[1];
    endfunction

    function automatic logic drive_level(input drive_e d);
        return d[0];
    endfunction

endpackage

// File: rtl/idelta_period_ctr.sv
module idelta_period_ctr #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             req
);
    logic [CNT_W-1:0] cnt_q;
    logic             req_q;

    assign wrap = &cnt_q;
    assign cnt  = cnt_q;
    assign req  = req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            req_q <= wrap;
        end
    end

    // R1: the counter steps by one each clock and folds back to zero
    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> cnt_q == $past(cnt_q) + 1'b1);
    a_r1_count_fold: assert property (@(posedge clk) disable iff (rst)
        wrap |=> cnt_q == '0);
    // R1: the request only appears in the first clock of a period
    a_r1_req_at_zero: assert property (@(posedge clk) disable iff (rst)
        req_q |-> cnt_q == '0);

endmodule

// File: rtl/idelta_cmd_store.sv
module idelta_cmd_store #(
    parameter int CNT_W   = 12,
    parameter int DELTA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               strobe,
    input  logic [DELTA_W-1:0] delta,
    input  logic               wrap,
    output logic [CNT_W-1:0]   act_mag,
    output logic               act_neg
);
    localparam int MAX_MAG = (2 ** CNT_W) - 1;
    localparam int ABS_W   = DELTA_W + 1;

    typedef struct packed {
        logic             neg;
        logic [CNT_W-1:0] mag;
    } cmd_t;

    logic [ABS_W-1:0] abs_w;
    logic             in_neg;
    cmd_t             incoming;
    cmd_t             pend_q;
    cmd_t             act_q;

    assign in_neg = delta[DELTA_W-1];

    // Absolute value computed one bit wider so the most negative code fits.
    always_comb begin
        if (in_neg)
            abs_w = -{delta[DELTA_W-1], delta};
        else
            abs_w = {1'b0, delta};
    end

    // Saturating clamp only exists when the input can exceed the counter range.
    generate
        if (ABS_W > CNT_W) begin : g_clamp
            logic over;
            assign over = abs_w > ABS_W'(MAX_MAG);
            always_comb begin
                incoming.neg = in_neg;
                incoming.mag = over ? CNT_W'(MAX_MAG) : abs_w[CNT_W-1:0];
            end
        end else begin : g_direct
            always_comb begin
                incoming.neg = in_neg;
                incoming.mag = CNT_W'(abs_w);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (wrap) begin
                act_q  <= pend_q;
                pend_q <= strobe ? incoming : '0;
            end else if (strobe) begin
                pend_q <= incoming;
            end
        end
    end

    assign act_mag = act_q.mag;
    assign act_neg = act_q.neg;

    // R5: the applied delta only changes at a period boundary
    a_r5_hold_mid_period: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_q));
    // R7: with no strobe since the last boundary, the next period carries nothing
    a_r7_consumed: assert property (@(posedge clk) disable iff (rst)
        (wrap && !strobe) |=> pend_q.mag == '0);

endmodule

// File: rtl/idelta_pulse_gen.sv
module idelta_pulse_gen
    import idelta_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] act_mag,
    input  logic             act_neg,
    output logic             drv_en,
    output logic             drv_level
);
    drive_e drive;
    logic   active;

    assign active    = cnt < act_mag;
    assign drive     = drive_select(active, act_neg);
    assign drv_en    = drive_enable(drive);
    assign drv_level = drive_level(drive);

    // R2: one contiguous run that can only start in the first clock of a period
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (drv_en && cnt != '0) |-> $past(drv_en));
    // R3: direction does not change within a run
    a_r3_level_stable: assert property (@(posedge clk) disable iff (rst)
        (drv_en && $past(drv_en)) |-> drv_level == $past(drv_level));
    // R4: a released pin reads level zero
    a_r4_level_quiet: assert property (@(posedge clk) disable iff (rst)
        !drv_en |-> !drv_level);

endmodule

// File: rtl/idelta_dac.sv
module idelta_dac #(
    parameter int CNT_W   = 12,
    parameter int DELTA_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               smp_strobe,
    input  logic [DELTA_W-1:0] smp_delta,
    output logic               drv_en,
    output logic               drv_level,
    output logic               smp_req
);
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic [CNT_W-1:0] act_mag;
    logic             act_neg;

    idelta_period_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk  (clk),
        .rst  (rst),
        .cnt  (cnt),
        .wrap (wrap),
        .req  (smp_req)
    );

    idelta_cmd_store #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_cmd (
        .clk     (clk),
        .rst     (rst),
        .strobe  (smp_strobe),
        .delta   (smp_delta),
        .wrap    (wrap),
        .act_mag (act_mag),
        .act_neg (act_neg)
    );

    idelta_pulse_gen #(.CNT_W(CNT_W)) u_pulse (
        .clk       (clk),
        .rst       (rst),
        .cnt       (cnt),
        .act_mag   (act_mag),
        .act_neg   (act_neg),
        .drv_en    (drv_en),
        .drv_level (drv_level)
    );

    // R9: outputs quiet in the first clock after reset
    a_r9_reset_state: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!drv_en && !drv_level && !smp_req));

endmodule

// File: tb/tb_idelta_dac.sv
module tb_idelta_dac;
    localparam int CNT_W   = 8;
    localparam int DELTA_W = 12;
    localparam int PER     = 2 ** CNT_W;
    localparam int MAXM    = PER - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_strobe = 1'b0;
    logic [DELTA_W-1:0] smp_delta = '0;
    logic drv_en, drv_level, smp_req;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    idelta_dac #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .smp_strobe (smp_strobe),
        .smp_delta  (smp_delta),
        .drv_en     (drv_en),
        .drv_level  (drv_level),
        .smp_req    (smp_req)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_req();
        do @(negedge clk); while (!smp_req);
    endtask

    task automatic send(input int d);
        smp_delta  = DELTA_W'(d);
        smp_strobe = 1'b1;
        @(negedge clk);
        smp_strobe = 1'b0;
    endtask

    // Entered at the negedge where smp_req is high; observes one full period.
    task automatic measure(input bit do_mid, input int mid_at, input int mid_d,
                           output int n, output int lvl, output int breaks,
                           output int quiet_bad, output int req_bad);
        bit prev = 1'b0;
        n = 0; lvl = -1; breaks = 0; quiet_bad = 0; req_bad = 0;
        for (int i = 0; i < PER; i++) begin
            if (i > 0) @(negedge clk);
            if (drv_en) begin
                n++;
                if (lvl < 0) lvl = int'(drv_level);
                else if (lvl != int'(drv_level)) breaks++;
                if (i > 0 && !prev) breaks++;
            end else if (drv_level) begin
                quiet_bad++;
            end
            if (smp_req != (i == 0)) req_bad++;
            prev = drv_en;
            if (do_mid && i == mid_at) begin
                smp_delta  = DELTA_W'(mid_d);
                smp_strobe = 1'b1;
            end
            if (do_mid && i == mid_at + 1) smp_strobe = 1'b0;
        end
    endtask

    task automatic check_period(input string req, input int n, input int lvl,
                                input int breaks, input int quiet_bad, input int req_bad,
                                input int exp_n, input int exp_lvl);
        chk(n == exp_n, {req, " enabled clocks"}, n, exp_n);
        if (exp_n > 0) chk(lvl == exp_lvl, {req, " R3 level"}, lvl, exp_lvl);
        chk(breaks == 0, {req, " R2 contiguous run"}, breaks, 0);
        chk(quiet_bad == 0, {req, " R4 released level"}, quiet_bad, 0);
        chk(req_bad == 0, {req, " R1 request timing"}, req_bad, 0);
    endtask

    task automatic run_delta(input int d, input int exp_n, input int exp_lvl, input string req);
        int n, lvl, br, qb, rb;
        wait_req();
        repeat (3) @(negedge clk);
        send(d);
        wait_req();
        measure(1'b0, 0, 0, n, lvl, br, qb, rb);
        check_period(req, n, lvl, br, qb, rb, exp_n, exp_lvl);
    endtask

    task automatic t_reset();
        int k = 0;
        int en_seen = 0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(!drv_en && !drv_level && !smp_req, "R9 outputs in reset",
            int'({drv_en, drv_level, smp_req}), 0);
        rst = 1'b0;
        do begin
            @(negedge clk);
            k++;
            if (drv_en) en_seen++;
        end while (!smp_req && k < 4 * PER);
        chk(k == PER, "R1 first request after reset", k, PER);
        chk(en_seen == 0, "R9 no drive after reset", en_seen, 0);
    endtask

    task automatic t_basic();
        run_delta(10, 10, 1, "R2 positive small");
        run_delta(-37, 37, 0, "R3 negative");
        run_delta(0, 0, 0, "R7 zero delta");
        run_delta(1, 1, 1, "R2 single clock");
        run_delta(MAXM, MAXM, 1, "R2 full magnitude");
        run_delta(-MAXM, MAXM, 0, "R8 negative limit");
    endtask

    task automatic t_clamp();
        run_delta(1000, MAXM, 1, "R8 positive clamp");
        run_delta(-2048, MAXM, 0, "R8 most negative code");
        run_delta(PER, MAXM, 1, "R8 one past limit");
    endtask

    task automatic t_mid_period();
        int n, lvl, br, qb, rb;
        wait_req();
        repeat (3) @(negedge clk);
        send(60);
        wait_req();
        measure(1'b1, 5, -20, n, lvl, br, qb, rb);
        check_period("R5 pulse unchanged by mid strobe", n, lvl, br, qb, rb, 60, 1);
        @(negedge clk);
        measure(1'b0, 0, 0, n, lvl, br, qb, rb);
        check_period("R5 mid strobe applied next", n, lvl, br, qb, rb, 20, 0);
    endtask

    task automatic t_last_wins();
        int n, lvl, br, qb, rb;
        wait_req();
        repeat (3) @(negedge clk);
        send(30);
        repeat (5) @(negedge clk);
        send(-70);
        wait_req();
        measure(1'b0, 0, 0, n, lvl, br, qb, rb);
        check_period("R6 last strobe wins", n, lvl, br, qb, rb, 70, 0);
        @(negedge clk);
        measure(1'b0, 0, 0, n, lvl, br, qb, rb);
        check_period("R7 no strobe gives idle period", n, lvl, br, qb, rb, 0, 0);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_clamp();
        t_mid_period();
        t_last_wins();
        summary();
    end

endmodule